// File: doc/BRIEF.md
# Smart-Card Bit-Rate Timer

This block produces the timing strobes for a card-side UART that follows ISO 7816. It counts card clock edges, not system clock edges. The card clock is given as a one-cycle enable, `card_clk_en_i`, that is synchronous to the system clock `clk_i`. The divider has two stages in series. The first is an 8-bit up-counter that returns to zero each time it reaches a programmed limit. The second is a prescaler that divides the first stage's terminal events by 31 or by 32. The product of the two stages gives one elementary time unit. The surrounding logic picks the limit and the prescaler ratio to match the card's F and D rate factors.

The block has two outputs. `bit_stb_o` pulses once per bit period. `mid_stb_o` pulses once near the middle of each bit period, and the receiver uses it to sample. The limit and the ratio are taken only while the block is disabled and at each bit boundary, so a bit period that has started always keeps its length. Dropping `enable_i` clears both stages. While the card clock is stopped, the count is frozen.

Top module: `sc_brg`

## Requirements
- R1: After reset, `bit_stb_o` and `mid_stb_o` are low.
- R2: With `presc32_i`=1 and reload value R, `bit_stb_o` pulses once every (R+1)×32 card clock ticks. A tick is a `clk_i` edge with `card_clk_en_i`=1.
- R3: With `presc32_i`=0 and reload value R, `bit_stb_o` pulses once every (R+1)×31 card clock ticks.
- R4: In every bit period, `mid_stb_o` pulses once, (R+1)×16 ticks after the period starts when the ratio is 32, and (R+1)×15 ticks after it starts when the ratio is 31. It never coincides with `bit_stb_o`.
- R5: Each strobe is high for exactly one `clk_i` cycle. It appears in the cycle that follows the tick completing its count.
- R6: While `card_clk_en_i` is low, both counter stages hold their state and no strobe is produced. Resuming the ticks continues the period where it stopped.
- R7: Changes to `reload_i` or `presc32_i` made while enabled take effect only from the next bit period. The period in progress, including its mid strobe, uses the old settings.
- R8: While `enable_i` is low, both stages are cleared and no strobe occurs. After `enable_i` rises, the first `bit_stb_o` comes a full period after the first enabled tick, however far the previous period had progressed.
- R9: The reload extremes 0 and 255 give periods of exactly 1× and 256× the prescaler ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| card_clk_en_i | input | 1 | One-cycle enable marking a card clock edge |
| enable_i | input | 1 | Run control; low clears both stages |
| reload_i | input | 8 | First-stage limit R (divide by R+1) |
| presc32_i | input | 1 | Prescaler ratio: 1 = divide by 32, 0 = divide by 31 |
| bit_stb_o | output | 1 | One-cycle strobe at each bit-period boundary |
| mid_stb_o | output | 1 | One-cycle strobe at the mid-bit sampling point |

## Verification
A fault in either counter stage shows up as a strobe at the wrong tick index. The error is visible at the first strobe after the fault, so within one bit period, and at the very next mid strobe if the fault is in the first half of the period. A settings register that is latched at the wrong time shifts the period in which a configuration change is made, and this appears at that period's mid or bit strobe. A stage that fails to clear or to hold shows up as the first strobe after re-enable or after a clock pause arriving at the wrong tick count. A stage that holds badly can also show up as a strobe while ticks are absent.

// File: rtl/sc_brg_pkg.sv
package sc_brg_pkg;

    localparam int unsigned SC_DIV_W     = 8;
    localparam int unsigned SC_PRE_BASE  = 31;

    typedef enum logic {
        PRESC_LOW  = 1'b0,
        PRESC_HIGH = 1'b1
    } presc_mode_e;

    function automatic int unsigned presc_ratio(input int unsigned base, input logic high);
        return base + (high ? 1 : 0);
    endfunction

endpackage

// File: rtl/sc_brg_div.sv
module sc_brg_div #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [DIV_W-1:0] limit_i,
    output logic             term_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_state_t;

    div_state_t cur_q, nxt_d;
    logic       term_d;

    always_comb begin
        nxt_d  = cur_q;
        term_d = run_i && tick_i && (cur_q.cnt == limit_i);
        if (!run_i) begin
            nxt_d.cnt = '0;
        end else if (tick_i) begin
            if (term_d) begin
                nxt_d.cnt = '0;
            end else begin
                nxt_d.cnt = DIV_W'(cur_q.cnt + 1'b1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign term_o = term_d;

    // R9: the count never passes the programmed limit
    p_div_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cur_q.cnt <= limit_i);

    // R6: no tick while running means the count holds
    p_div_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && !tick_i) |=> $stable(cur_q.cnt));

    // R8: disabled means cleared
    p_div_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (cur_q.cnt == '0));

endmodule

// File: rtl/sc_brg_presc.sv
module sc_brg_presc #(
    parameter int unsigned BASE = 31
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic step_i,
    input  logic high_i,
    output logic wrap_o,
    output logic half_o
);

    localparam int unsigned PRE_W = $clog2(BASE + 2);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_state_t;

    pre_state_t       cur_q, nxt_d;
    logic [PRE_W-1:0] last_idx;
    logic [PRE_W-1:0] half_idx;
    logic             wrap_d;
    logic             half_d;

    always_comb begin
        last_idx = high_i ? PRE_W'(BASE) : PRE_W'(BASE - 1);
        half_idx = high_i ? PRE_W'((BASE + 1) / 2 - 1) : PRE_W'(BASE / 2 - 1);
        nxt_d    = cur_q;
        wrap_d   = run_i && step_i && (cur_q.cnt == last_idx);
        half_d   = run_i && step_i && (cur_q.cnt == half_idx);
        if (!run_i) begin
            nxt_d.cnt = '0;
        end else if (step_i) begin
            if (wrap_d) begin
                nxt_d.cnt = '0;
            end else begin
                nxt_d.cnt = PRE_W'(cur_q.cnt + 1'b1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign wrap_o = wrap_d;
    assign half_o = half_d;

    // R3: the prescaler count stays inside the selected ratio
    p_pre_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cur_q.cnt <= last_idx);

    // R6: the prescaler only moves on a first-stage terminal event
    p_pre_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && !step_i) |=> $stable(cur_q.cnt));

endmodule

// File: rtl/sc_brg.sv
module sc_brg
    import sc_brg_pkg::*;
#(
    parameter int unsigned DIV_W    = SC_DIV_W,
    parameter int unsigned PRE_BASE = SC_PRE_BASE
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             card_clk_en_i,
    input  logic             enable_i,
    input  logic [DIV_W-1:0] reload_i,
    input  logic             presc32_i,
    output logic             bit_stb_o,
    output logic             mid_stb_o
);

    typedef struct packed {
        logic [DIV_W-1:0] reload;
        presc_mode_e      mode;
        logic             bit_stb;
        logic             mid_stb;
    } top_state_t;

    top_state_t cur_q, nxt_d;
    logic       term;
    logic       wrap;
    logic       half;

    sc_brg_div #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (enable_i),
        .tick_i  (card_clk_en_i),
        .limit_i (cur_q.reload),
        .term_o  (term)
    );

    sc_brg_presc #(
        .BASE (PRE_BASE)
    ) u_pre (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (enable_i),
        .step_i (term),
        .high_i (cur_q.mode == PRESC_HIGH),
        .wrap_o (wrap),
        .half_o (half)
    );

    always_comb begin
        nxt_d = cur_q;
        if (!enable_i || wrap) begin
            nxt_d.reload = reload_i;
            nxt_d.mode   = presc32_i ? PRESC_HIGH : PRESC_LOW;
        end
        nxt_d.bit_stb = wrap;
        nxt_d.mid_stb = half;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign bit_stb_o = cur_q.bit_stb;
    assign mid_stb_o = cur_q.mid_stb;

    // R5: strobes last a single cycle
    p_bit_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bit_stb_o |=> !bit_stb_o);

    // R4: mid and bit strobes never coincide
    p_strobe_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(bit_stb_o && mid_stb_o));

    // R6: a strobe always follows a card clock tick
    p_strobe_tick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bit_stb_o || mid_stb_o) |-> $past(card_clk_en_i && enable_i));

    // R8: no strobe after a disabled cycle
    p_quiet_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> (!bit_stb_o && !mid_stb_o));

    // R7: settings stay frozen inside a running period
    p_cfg_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enable_i && !wrap) |=> ($stable(cur_q.reload) && $stable(cur_q.mode)));

endmodule

// File: tb/sc_brg_tb.sv
module sc_brg_tb;

    typedef struct {
        int    t;
        string req;
    } exp_t;

    logic       clk;
    logic       rst_n;
    logic       card_en;
    logic       enable;
    logic [7:0] reload;
    logic       sel32;
    logic       bit_stb;
    logic       mid_stb;

    int   n_checks;
    int   n_fail;
    int   tcount;
    int   base;
    int   cyc;
    bit   done;
    logic prev_bit;
    logic prev_mid;

    exp_t bit_q[$];
    exp_t mid_q[$];

    sc_brg u_dut (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .card_clk_en_i (card_en),
        .enable_i      (enable),
        .reload_i      (reload),
        .presc32_i     (sel32),
        .bit_stb_o     (bit_stb),
        .mid_stb_o     (mid_stb)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    // tick counter of the bench, relative to the latest enable
    always @(posedge clk) begin
        if (!enable) tcount <= 0;
        else if (card_en) tcount <= tcount + 1;
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung at cycle %0d expected end before %0d", cyc, 150000);
            finish_run();
        end
    end

    // monitor: pops expected strobes and compares tick indices
    always @(negedge clk) begin
        if (rst_n) begin
            if (bit_stb) begin
                n_checks++;
                if (prev_bit) begin
                    n_fail++;
                    $display("FAIL R5 bit strobe wider than one cycle at tick %0d expected width 1", tcount);
                end else if (bit_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R8 unexpected bit strobe at tick %0d expected none", tcount);
                end else begin
                    exp_t e;
                    e = bit_q.pop_front();
                    if (e.t != tcount) begin
                        n_fail++;
                        $display("FAIL %s bit strobe at tick %0d expected %0d", e.req, tcount, e.t);
                    end
                end
            end
            if (mid_stb) begin
                n_checks++;
                if (prev_mid) begin
                    n_fail++;
                    $display("FAIL R5 mid strobe wider than one cycle at tick %0d expected width 1", tcount);
                end else if (mid_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R6 unexpected mid strobe at tick %0d expected none", tcount);
                end else begin
                    exp_t e;
                    e = mid_q.pop_front();
                    if (e.t != tcount) begin
                        n_fail++;
                        $display("FAIL %s mid strobe at tick %0d expected %0d", e.req, tcount, e.t);
                    end
                end
            end
            prev_bit = bit_stb;
            prev_mid = mid_stb;
        end
    end

    task automatic push_period(input int r, input bit hi, input string req);
        int n;
        n = hi ? 32 : 31;
        mid_q.push_back('{t: base + (n / 2) * (r + 1), req: req});
        bit_q.push_back('{t: base + n * (r + 1), req: req});
        base += n * (r + 1);
    endtask

    task automatic start(input int r, input bit hi);
        @(negedge clk);
        enable  = 1'b0;
        card_en = 1'b0;
        reload  = 8'(r);
        sel32   = hi;
        @(negedge clk);
        @(negedge clk);
        base   = 0;
        enable = 1'b1;
    endtask

    // gap: idle cycles with the card clock stopped between ticks
    task automatic ticks(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            card_en = 1'b1;
            @(negedge clk);
            card_en = 1'b0;
            for (int g = 0; g < gap; g++) @(negedge clk);
        end
        card_en = 1'b0;
    endtask

    task automatic settle(input string req);
        card_en = 1'b0;
        repeat (3) @(negedge clk);
        n_checks++;
        if (bit_q.size() != 0 || mid_q.size() != 0) begin
            n_fail++;
            $display("FAIL %s pending strobes bit=%0d mid=%0d expected 0 0", req, bit_q.size(), mid_q.size());
        end
        bit_q.delete();
        mid_q.delete();
    endtask

    initial begin
        n_checks = 0; n_fail = 0; cyc = 0; done = 1'b0;
        tcount = 0; base = 0; prev_bit = 1'b0; prev_mid = 1'b0;
        rst_n = 1'b0; card_en = 1'b0; enable = 1'b0; reload = '0; sel32 = 1'b0;
        repeat (3) @(negedge clk);
        n_checks++;
        if (bit_stb !== 1'b0 || mid_stb !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 strobes in reset bit=%b mid=%b expected 0 0", bit_stb, mid_stb);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_checks++;
        if (bit_stb !== 1'b0 || mid_stb !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 strobes after reset bit=%b mid=%b expected 0 0", bit_stb, mid_stb);
        end

        // R2: ratio 32, R=3, three periods back to back
        start(3, 1'b1);
        for (int k = 0; k < 3; k++) push_period(3, 1'b1, "R2");
        ticks(3 * 128, 0);
        settle("R2");

        // R3: ratio 31, R=6, two periods
        start(6, 1'b0);
        for (int k = 0; k < 2; k++) push_period(6, 1'b0, "R3");
        ticks(2 * 217, 0);
        settle("R3");

        // R4: mid point check with ratio 31, R=1 and gapped ticks
        start(1, 1'b0);
        push_period(1, 1'b0, "R4");
        ticks(62, 2);
        settle("R4");

        // R9: reload extremes
        start(0, 1'b0);
        for (int k = 0; k < 2; k++) push_period(0, 1'b0, "R9");
        ticks(62, 0);
        settle("R9");
        start(255, 1'b1);
        push_period(255, 1'b1, "R9");
        ticks(8192, 0);
        settle("R9");

        // R6: long stop of the card clock mid-period
        start(2, 1'b1);
        push_period(2, 1'b1, "R6");
        ticks(40, 0);
        repeat (200) @(negedge clk);
        ticks(56, 1);
        settle("R6");

        // R7: change settings inside the first period
        start(3, 1'b1);
        push_period(3, 1'b1, "R7");
        push_period(5, 1'b0, "R7");
        ticks(10, 0);
        reload = 8'd5;
        sel32  = 1'b0;
        ticks(128 - 10 + 186, 0);
        settle("R7");

        // R8: abort mid-period, ticks while disabled, restart
        start(1, 1'b1);
        mid_q.push_back('{t: 32, req: "R8"});
        ticks(40, 0);
        settle("R8");
        enable = 1'b0;
        ticks(20, 0);
        enable = 1'b1;
        base = 0;
        push_period(1, 1'b1, "R8");
        ticks(64, 0);
        settle("R8");
        enable = 1'b0;
        repeat (4) @(negedge clk);

        finish_run();
    end

endmodule